// File: doc/BRIEF.md
# Stepped Frequency Sweep Sequencer

This block produces the tuning word that drives a numerically controlled oscillator through a stepped frequency sweep. A start pulse captures a start word, an unsigned increment, a direction, a step count, a dwell length and a dwell-unit mode. The sweep then walks from the start word towards an end point that is never programmed. That end point follows from the start word, the increment and the step count.

Each frequency is held for a dwell that is measured in one of two units. The first unit is the master clock period. The second is one cycle of the synthesized waveform, which a neighbouring phase accumulator reports on `cyc_tick_i`. A one-cycle strobe marks every new frequency. `busy_o` covers the whole sweep, and `done_o` marks that the final frequency is being held.

Top module: `sweep_seq`

## Requirements
- R1: While `rst_ni` is low, `freq_o` is 0 and `step_o`, `busy_o` and `done_o` are 0.
- R2: A `start_i` pulse while not busy puts `start_word_i` on `freq_o` one clock later. In that same cycle `step_o` and `busy_o` are 1 and `done_o` is 0.
- R3: With `dir_down_i`=0, the k-th frequency after the start word is start + k·incr modulo 2^24. The 23-bit `incr_i` is zero-extended before the addition.
- R4: With `dir_down_i`=1, the k-th frequency after the start word is start − k·incr modulo 2^24, again with `incr_i` zero-extended.
- R5: With `mode_cycles_i`=0, every frequency, the final one included, stays on `freq_o` for exactly `interval_i` clock cycles.
- R6: With `mode_cycles_i`=1, every frequency is held until `interval_i` cycles have been seen with `cyc_tick_i` high. A tick is counted at the clock edge that samples it.
- R7: The sweep presents exactly `n_incr_i`+1 frequencies. After the dwell of the last one, `busy_o` falls, `done_o` rises and `freq_o` keeps the final frequency.
- R8: A `start_i` pulse while `busy_o` is 1 has no effect. This holds in the cycle where the final dwell ends as well.
- R9: `step_o` is high for one cycle exactly when a new sweep frequency first appears on `freq_o`. In any other cycle `freq_o` does not change.
- R10: An `n_incr_i` below 2 is taken as 2, and an `interval_i` below 2 is taken as 2.
- R11: All sweep settings are captured at the accepted start. Changes on those inputs during the sweep do not alter it.
- R12: `done_o` and the final frequency stay until the next accepted start. That start clears `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sweep start pulse |
| start_word_i | input | 24 | First tuning word of the sweep |
| incr_i | input | 23 | Unsigned step size |
| dir_down_i | input | 1 | 1: subtract step, 0: add step |
| n_incr_i | input | 12 | Number of increments (2..4095) |
| interval_i | input | 11 | Dwell length in base units (2..2047) |
| mode_cycles_i | input | 1 | 1: dwell counts waveform cycles, 0: clock periods |
| cyc_tick_i | input | 1 | One pulse per output waveform cycle |
| freq_o | output | 24 | Current tuning word |
| step_o | output | 1 | New-frequency strobe |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished, final word held |

## Verification
Two functions can fall in the same cycle: the expiry of the final dwell, which ends the sweep, and a new start request. To provoke this, the bench raises `start_i` with a different start word in exactly the cycle whose closing edge ends the last dwell. It then expects `done_o` to rise with the old final word still on `freq_o` and no strobe. A second collision places a `cyc_tick_i` pulse on the cycle of the accepted start, and the bench checks that this tick does not shorten the first dwell.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int unsigned FREQ_W = 24;
  localparam int unsigned INCR_W = 23;
  localparam int unsigned NSTEP_W = 12;
  localparam int unsigned IVAL_W = 11;
  localparam int unsigned MIN_COUNT = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sweep_state_e;
endpackage

// File: rtl/sweep_dwell_timer.sv
module sweep_dwell_timer #(
  parameter int unsigned IVAL_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              active_i,
  input  logic              unit_i,
  input  logic [IVAL_W-1:0] ival_i,
  output logic              end_o
);
  logic [IVAL_W-1:0] cnt_q;
  logic              hit;

  assign hit   = (cnt_q == ival_i - IVAL_W'(1));
  assign end_o = active_i & unit_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (active_i && unit_i)   cnt_q <= hit ? '0 : cnt_q + IVAL_W'(1);
  end

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cnt_q < ival_i));
  p_no_count_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sweep_step_counter.sv
module sweep_step_counter #(
  parameter int unsigned NSTEP_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               adv_i,
  input  logic [NSTEP_W-1:0] n_i,
  output logic               last_o
);
  logic [NSTEP_W-1:0] k_q;

  assign last_o = (k_q == n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     k_q <= '0;
    else if (clr_i)  k_q <= '0;
    else if (adv_i)  k_q <= k_q + NSTEP_W'(1);
  end

  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_q <= n_i);
  p_adv_not_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> !last_o);
endmodule

// File: rtl/sweep_word_alu.sv
module sweep_word_alu #(
  parameter int unsigned FREQ_W = 24,
  parameter int unsigned INCR_W = 23
) (
  input  logic [FREQ_W-1:0] cur_i,
  input  logic [INCR_W-1:0] incr_i,
  input  logic              down_i,
  output logic [FREQ_W-1:0] nxt_o
);
  localparam int unsigned PAD_W = FREQ_W - INCR_W;
  logic [FREQ_W-1:0] incr_ext;

  assign incr_ext = {{PAD_W{1'b0}}, incr_i};
  assign nxt_o    = down_i ? (cur_i - incr_ext) : (cur_i + incr_ext);

  always_comb begin
    p_inverse_r3: assert ((down_i ? (nxt_o + incr_ext) : (nxt_o - incr_ext)) == cur_i);
  end
endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
  import sweep_pkg::*;
#(
  parameter int unsigned FW = FREQ_W,
  parameter int unsigned IW = INCR_W,
  parameter int unsigned NW = NSTEP_W,
  parameter int unsigned TW = IVAL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [FW-1:0] start_word_i,
  input  logic [IW-1:0] incr_i,
  input  logic          dir_down_i,
  input  logic [NW-1:0] n_incr_i,
  input  logic [TW-1:0] interval_i,
  input  logic          mode_cycles_i,
  input  logic          cyc_tick_i,
  output logic [FW-1:0] freq_o,
  output logic          step_o,
  output logic          busy_o,
  output logic          done_o
);
  sweep_state_e  state_q;
  logic [FW-1:0] freq_q, freq_nxt;
  logic [IW-1:0] incr_q;
  logic [NW-1:0] n_q, n_eff;
  logic [TW-1:0] ival_q, ival_eff;
  logic          down_q, mode_q, step_q;
  logic          start_ok, run, unit, dwell_end, last;

  assign n_eff    = (n_incr_i < NW'(MIN_COUNT)) ? NW'(MIN_COUNT) : n_incr_i;
  assign ival_eff = (interval_i < TW'(MIN_COUNT)) ? TW'(MIN_COUNT) : interval_i;
  assign run      = (state_q == ST_RUN);
  assign start_ok = start_i && !run;
  assign unit     = mode_q ? cyc_tick_i : 1'b1;

  sweep_dwell_timer #(.IVAL_W(TW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_ok),
    .active_i (run),
    .unit_i   (unit),
    .ival_i   (ival_q),
    .end_o    (dwell_end)
  );

  sweep_step_counter #(.NSTEP_W(NW)) u_steps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .adv_i  (dwell_end && !last),
    .n_i    (n_q),
    .last_o (last)
  );

  sweep_word_alu #(.FREQ_W(FW), .INCR_W(IW)) u_alu (
    .cur_i  (freq_q),
    .incr_i (incr_q),
    .down_i (down_q),
    .nxt_o  (freq_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      freq_q  <= '0;
      incr_q  <= '0;
      n_q     <= NW'(MIN_COUNT);
      ival_q  <= TW'(MIN_COUNT);
      down_q  <= 1'b0;
      mode_q  <= 1'b0;
      step_q  <= 1'b0;
    end else begin
      step_q <= 1'b0;
      if (start_ok) begin
        state_q <= ST_RUN;
        freq_q  <= start_word_i;
        incr_q  <= incr_i;
        n_q     <= n_eff;
        ival_q  <= ival_eff;
        down_q  <= dir_down_i;
        mode_q  <= mode_cycles_i;
        step_q  <= 1'b1;
      end else if (dwell_end) begin
        if (last) begin
          state_q <= ST_DONE;
        end else begin
          freq_q <= freq_nxt;
          step_q <= 1'b1;
        end
      end
    end
  end

  assign freq_o = freq_q;
  assign step_o = step_q;
  assign busy_o = run;
  assign done_o = (state_q == ST_DONE);

  p_start_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && step_o && !done_o && freq_o == $past(start_word_i)));
  p_busy_done_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> (done_o || (busy_o && $past(busy_o))));
  p_stable_no_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_o |-> $stable(freq_o));
  p_step_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && done_o) |-> 1'b0 || !step_o);
  p_done_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(freq_o)));
endmodule

// File: tb/sim_sweep_seq.sv
module sim_sweep_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_word = '0;
  logic [22:0] incr = '0;
  logic        dir_down = 1'b0;
  logic [11:0] n_incr = '0;
  logic [10:0] interval = '0;
  logic        mode_cyc = 1'b0;
  logic        tick = 1'b0;
  logic [23:0] freq;
  logic        step, busy, done;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sweep_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_word_i(start_word),
    .incr_i(incr), .dir_down_i(dir_down), .n_incr_i(n_incr), .interval_i(interval),
    .mode_cycles_i(mode_cyc), .cyc_tick_i(tick),
    .freq_o(freq), .step_o(step), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run exceeded cycle limit");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Runs a sweep and checks every cycle against a model built from the requirements.
  // gap: tick period in cycles (cycle mode); ign_at: cycle index to inject a busy start
  // (-1 none); hit_end: inject a start in the cycle the final dwell ends; scramble: alter inputs.
  task automatic run_sweep(input string tag, input logic [23:0] sw, input logic [22:0] inc,
                           input logic dn, input int n, input int iv, input logic md,
                           input int gap, input int ign_at, input logic hit_end,
                           input logic scramble, input logic tick_on_start);
    int n_eff, iv_eff, k, cnt, cyc;
    logic [23:0] ef;
    logic eb, ed, es, unit;
    n_eff  = (n < 2) ? 2 : n;
    iv_eff = (iv < 2) ? 2 : iv;
    @(negedge clk);
    start = 1'b1; start_word = sw; incr = inc; dir_down = dn;
    n_incr = 12'(n); interval = 11'(iv); mode_cyc = md; tick = tick_on_start;
    @(negedge clk);
    start = 1'b0; tick = 1'b0;
    if (scramble) begin
      start_word = ~sw; incr = ~inc; dir_down = ~dn; n_incr = 12'd7; interval = 11'd9;
      mode_cyc = ~md;
    end
    ef = sw; eb = 1'b1; ed = 1'b0; es = 1'b1; k = 0; cnt = 0; cyc = 0;
    forever begin
      chk({tag, " R9 step"}, 32'(step), 32'(es));
      chk({tag, " R3/R4 freq"}, 32'(freq), 32'(ef));
      chk({tag, " R7 busy"}, 32'(busy), 32'(eb));
      chk({tag, " R7 done"}, 32'(done), 32'(ed));
      if (ed) break;
      tick  = md && (cyc % gap == 0);
      unit  = md ? tick : 1'b1;
      start = 1'b0;
      if (cyc == ign_at) begin
        start = 1'b1; start_word = 24'h5A5A5A;
      end
      es = 1'b0;
      if (unit) begin
        if (cnt == iv_eff - 1) begin
          cnt = 0;
          if (k == n_eff) begin
            eb = 1'b0; ed = 1'b1;
            if (hit_end) begin
              start = 1'b1; start_word = 24'h123456;
            end
          end else begin
            k++;
            ef = dn ? ef - {1'b0, inc} : ef + {1'b0, inc};
            es = 1'b1;
          end
        end else cnt++;
      end
      cyc++;
      @(negedge clk);
      start = 1'b0; tick = 1'b0;
    end
    // R12: done and final word persist with no start
    repeat (3) @(negedge clk);
    chk({tag, " R12 done held"}, 32'(done), 32'd1);
    chk({tag, " R12 freq held"}, 32'(freq), 32'(ef));
    chk({tag, " R12 no step"}, 32'(step), 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 freq", 32'(freq), 32'd0);
    chk("R1 step", 32'(step), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_up_wrap;   // R2 R3 R5
    run_sweep("up", 24'hFFFFF0, 23'h10, 1'b0, 3, 3, 1'b0, 1, -1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_down_wrap; // R4 R5
    run_sweep("down", 24'h000005, 23'h3, 1'b1, 4, 2, 1'b0, 1, -1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_big_incr;  // R3 zero extension
    run_sweep("bigup", 24'h000100, 23'h7FFFFF, 1'b0, 2, 2, 1'b0, 1, -1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_cycle_mode; // R6, tick at start ignored
    run_sweep("cyc", 24'h001000, 23'h100, 1'b0, 2, 2, 1'b1, 3, -1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_clamp;      // R10
    run_sweep("clamp", 24'h000200, 23'h20, 1'b0, 0, 1, 1'b0, 1, -1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_busy_start; // R8
    run_sweep("ignore", 24'h000300, 23'h1, 1'b0, 3, 4, 1'b0, 1, 5, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_end_collide; // R8 at final dwell expiry
    run_sweep("collide", 24'h0000A0, 23'h5, 1'b1, 2, 3, 1'b0, 1, -1, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_scramble;   // R11
    run_sweep("latch", 24'h00ABCD, 23'h11, 1'b0, 3, 3, 1'b0, 1, -1, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_restart;    // R12: next start clears done
    @(negedge clk);
    start = 1'b1; start_word = 24'h777777; n_incr = 12'd2; interval = 11'd2;
    incr = 23'd1; dir_down = 1'b0; mode_cyc = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk("R12 done cleared", 32'(done), 32'd0);
    chk("R2 busy on restart", 32'(busy), 32'd1);
    chk("R2 start word", 32'(freq), 32'h777777);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_up_wrap();
    t_down_wrap();
    t_big_incr();
    t_cycle_mode();
    t_clamp();
    t_busy_start();
    t_end_collide();
    t_scramble();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule